// File: doc/BRIEF.md
# Multi-core interrupt routing controller

This block gathers level-sensitive interrupt sources into one global pending vector. Each source has an enable bit, and each enabled source is steered to one of four cores and to one of four parent interrupt lines on that core. Every core has its own status copy of the sources routed to it. A parent line is high while at least one source in that core's copy maps to that line.

Software sets the block up through a byte-addressed register window. Accesses can be 1, 4 or 8 bytes wide, and every access carries the id of the core that makes it. The block answers each accepted access one cycle later. Some updates touch more than one source: enabling or disabling pending sources, clearing status bits, and moving pending sources to another core. These updates are applied one source per cycle, and `busy_o` holds off new accesses until they are done.

Top module: `irq_router`

## Requirements
- R1: After reset every register reads zero, `irq_o` is zero and `busy_o` is low.
- R2: An access is flagged with `err_o`, makes no state change and returns zero data in two cases: any byte lies outside the mapped windows, or the size code is 3. Mapped windows, with E = NSRC/8:
  - 0x0A0+32 (node type)
  - 0x0C0+NSRC/32 (line map)
  - 0x200+E (enable)
  - 0x280+32 (bounce)
  - 0x300+E (global pending)
  - 0x400 + 0x100·c + E (core status, c < NCORE)
  - 0x800+NSRC (core map)
- R3: A source that rises while enabled sets its bit in the status copy of its target core. Parent line `irq_o[4·core+line]` is high exactly while that copy holds a bit for a source on that line. The line for source s is the index of the lowest set bit of line-map byte s/32. If that index is 4 or more, or the byte is zero, line 0 is used. The line is recomputed whenever the line map changes.
- R4: The target core of source s is the index of the lowest set bit of core-map byte s. If that index is NCORE or more, or the byte is zero, core 0 is used.
- R5: A source that falls loses its status bit. Its parent line drops only when no other status bit remains on that core and line.
- R6: The global pending window shows the latched level of every source, with source s at byte s/8, bit s%8. A source that rises while disabled is not routed. Writes to this window are ignored without error.
- R7: A write to the core status window clears, in the requesting core's copy, the bits written as 1. Each source actually cleared is then deasserted on its mapped core. The core field of the address (bits 9:8) is ignored: the requester's own copy is always used.
- R8: When a pending source's enable bit goes 0→1 it is routed as a rise. When it goes 1→0 it is routed as a fall.
- R9: When a pending source's core-map byte changes its target core, the source's status bit moves from the old core to the new one. A write that leaves the target core unchanged starts no update.
- R10: Node-type and bounce bytes are stored and read back, and have no effect on routing.
- R11: Size codes 0, 1 and 2 select 1, 4 and 8 bytes. The address is aligned down to the access size, and bytes are little-endian.
- R12: Multi-source updates are applied one source per cycle, lowest index first. `busy_o` is high for exactly as many cycles as there are sources to update. A request made while `busy_o` is high is dropped and gets no response.
- R13: An accepted request (`req_i` high while `busy_o` is low) is answered with `rsp_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| src_i | input | NSRC | Source interrupt levels |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0: 1 byte, 1: 4 bytes, 2: 8 bytes |
| core_i | input | CW | Requesting core id |
| addr_i | input | 12 | Byte offset in the register window |
| wdata_i | input | 64 | Write data, little-endian |
| rsp_o | output | 1 | Response valid |
| rdata_o | output | 64 | Read data |
| err_o | output | 1 | Access error |
| busy_o | output | 1 | Multi-source update in progress |
| irq_o | output | NCORE*4 | Parent lines, bit 4·core+line |

## Verification
The bench builds the block with NSRC=64 and NCORE=4. With that setting the global pending and enable windows are 8 bytes each, so one 8-byte read shows every source at once. Each source can then be raised alone and its expected core and line derived arithmetically from a repeating core-map pattern, covering every decode corner: an empty byte, bits beyond the core count, and several bits set. The small windows also put the out-of-range offsets just past the enable and status windows within easy reach.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NSRC  = 256,
  parameter int NCORE = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic [NSRC-1:0]           src_i,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [1:0]                size_i,
  input  logic [$clog2(NCORE)-1:0]  core_i,
  input  logic [11:0]               addr_i,
  input  logic [63:0]               wdata_i,
  output logic                      rsp_o,
  output logic [63:0]               rdata_o,
  output logic                      err_o,
  output logic                      busy_o,
  output logic [NCORE*4-1:0]        irq_o
);
  localparam int NLINE = 4;
  localparam int CW    = $clog2(NCORE);
  localparam int SW    = $clog2(NSRC);
  localparam int ENB   = NSRC / 8;
  localparam int IPB   = NSRC / 32;
  localparam int NTB   = 32;
  localparam int A_NT  = 'h0A0;
  localparam int A_IPM = 'h0C0;
  localparam int A_EN  = 'h200;
  localparam int A_BO  = 'h280;
  localparam int A_GS  = 'h300;
  localparam int A_CS  = 'h400;
  localparam int A_CM  = 'h800;

  logic [NSRC-1:0] en_q, en_d, pend_q, pend_d;
  logic [NSRC-1:0] cst_q [NCORE];
  logic [NSRC-1:0] cst_d [NCORE];
  logic [7:0]      cmap_q [NSRC];
  logic [7:0]      cmap_d [NSRC];
  logic [CW-1:0]   eff_q [NSRC];
  logic [CW-1:0]   eff_d [NSRC];
  logic [7:0]      ipm_q [IPB];
  logic [7:0]      ipm_d [IPB];
  logic [7:0]      nt_q [NTB];
  logic [7:0]      nt_d [NTB];
  logic [7:0]      bo_q [NTB];
  logic [7:0]      bo_d [NTB];
  logic [63:0]     wa_q, wa_d, wd_q, wd_d, wm_q, wm_d;
  logic [SW-1:0]   wb_q, wb_d;
  logic            rsp_d, err_d;
  logic [63:0]     rdata_d;
  logic [NSRC-1:0] lmask [NLINE];

  function automatic int lsb8(input logic [7:0] v);
    int r;
    r = 8;
    for (int i = 7; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  function automatic int lsb64(input logic [63:0] v);
    int r;
    r = 0;
    for (int i = 63; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [CW-1:0] core_dec(input logic [7:0] v);
    int i;
    i = lsb8(v);
    return (i < NCORE) ? CW'(i) : '0;
  endfunction

  function automatic logic in_win(input int off, input int base, input int len);
    return (off >= base) && (off < base + len);
  endfunction

  function automatic logic in_cs(input int off);
    return (off >= A_CS) && (off < A_CM) && (((off - A_CS) >> 8) < NCORE)
           && (((off - A_CS) & 255) < ENB);
  endfunction

  function automatic logic byte_ok(input int off);
    return in_win(off, A_NT, NTB) || in_win(off, A_IPM, IPB) || in_win(off, A_EN, ENB)
        || in_win(off, A_BO, NTB) || in_win(off, A_GS, ENB) || in_cs(off)
        || in_win(off, A_CM, NSRC);
  endfunction

  assign busy_o = |(wa_q | wd_q | wm_q);

  always_comb begin
    for (int l = 0; l < NLINE; l++) lmask[l] = '0;
    for (int s = 0; s < NSRC; s++) begin
      int li;
      li = lsb8(ipm_q[s / 32]);
      if (li >= NLINE) li = 0;
      lmask[li][s] = 1'b1;
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    for (genvar l = 0; l < NLINE; l++) begin : g_line
      assign irq_o[c*NLINE+l] = |(cst_q[c] & lmask[l]);
    end
  end

  always_comb begin
    int s, pick, nb, a, off, j;
    logic ok;
    logic [7:0] b, old;
    logic [CW-1:0] nc;
    logic [63:0] rd;

    en_d = en_q;  pend_d = src_i;  cst_d = cst_q;  cmap_d = cmap_q;  eff_d = eff_q;
    ipm_d = ipm_q;  nt_d = nt_q;  bo_d = bo_q;
    wa_d = wa_q;  wd_d = wd_q;  wm_d = wm_q;  wb_d = wb_q;
    rsp_d = 1'b0;  err_d = 1'b0;  rdata_d = '0;
    rd = '0;  ok = 1'b1;  b = '0;  old = '0;  nc = '0;  off = 0;  j = 0;

    // one queued source update per cycle, lowest index first
    pick = lsb64(wa_q | wd_q | wm_q);
    s = int'(wb_q) + pick;
    if (busy_o && s < NSRC) begin
      if (wa_q[pick] && en_q[s] && pend_q[s]) cst_d[eff_q[s]][s] = 1'b1;
      if (wd_q[pick]) cst_d[eff_q[s]][s] = 1'b0;
      if (wm_q[pick]) begin
        nc = core_dec(cmap_q[s]);
        cst_d[eff_q[s]][s] = 1'b0;
        eff_d[s] = nc;
        if (en_q[s] && pend_q[s]) cst_d[nc][s] = 1'b1;
      end
      wa_d[pick] = 1'b0;  wd_d[pick] = 1'b0;  wm_d[pick] = 1'b0;
    end

    // register access
    case (size_i)
      2'd0:    nb = 1;
      2'd1:    nb = 4;
      2'd2:    nb = 8;
      default: nb = 0;
    endcase
    a = (nb == 0) ? 0 : (int'(addr_i) & ~(nb - 1));
    if (nb == 0) ok = 1'b0;
    for (int k = 0; k < 8; k++) if (k < nb && !byte_ok(a + k)) ok = 1'b0;

    if (req_i && !busy_o) begin
      rsp_d = 1'b1;
      err_d = !ok;
      if (ok) begin
        for (int k = 0; k < 8; k++) begin
          if (k < nb) begin
            off = a + k;
            b = wdata_i[k*8 +: 8];
            if (in_win(off, A_NT, NTB)) begin
              rd[k*8 +: 8] = nt_q[off - A_NT];
              if (we_i) nt_d[off - A_NT] = b;
            end else if (in_win(off, A_IPM, IPB)) begin
              rd[k*8 +: 8] = ipm_q[off - A_IPM];
              if (we_i) ipm_d[off - A_IPM] = b;
            end else if (in_win(off, A_EN, ENB)) begin
              j = off - A_EN;
              old = en_q[j*8 +: 8];
              rd[k*8 +: 8] = old;
              if (we_i) begin
                en_d[j*8 +: 8] = b;
                wb_d = SW'((a - A_EN) * 8);
                for (int t = 0; t < 8; t++) begin
                  if (b[t] && !old[t] && pend_q[j*8+t]) wa_d[k*8+t] = 1'b1;
                  if (!b[t] && old[t] && pend_q[j*8+t]) wd_d[k*8+t] = 1'b1;
                end
              end
            end else if (in_win(off, A_BO, NTB)) begin
              rd[k*8 +: 8] = bo_q[off - A_BO];
              if (we_i) bo_d[off - A_BO] = b;
            end else if (in_win(off, A_GS, ENB)) begin
              rd[k*8 +: 8] = pend_q[(off - A_GS)*8 +: 8];
            end else if (in_cs(off)) begin
              j = (off - A_CS) & 255;
              old = cst_q[core_i][j*8 +: 8];
              rd[k*8 +: 8] = old;
              if (we_i) begin
                cst_d[core_i][j*8 +: 8] = old & ~b;
                wd_d[k*8 +: 8] = old & b;
                wb_d = SW'(((a - A_CS) & 255) * 8);
              end
            end else begin
              j = off - A_CM;
              rd[k*8 +: 8] = cmap_q[j];
              if (we_i) begin
                cmap_d[j] = b;
                nc = core_dec(b);
                wb_d = SW'(a - A_CM);
                if (nc != eff_q[j]) begin
                  if (pend_q[j]) wm_d[k] = 1'b1;
                  else eff_d[j] = nc;
                end
              end
            end
          end
        end
        if (!we_i) rdata_d = rd;
      end
    end

    // source level edges take effect last
    for (int i = 0; i < NSRC; i++) begin
      if (src_i[i] && !pend_q[i] && en_d[i]) cst_d[eff_d[i]][i] = 1'b1;
      if (!src_i[i] && pend_q[i])
        for (int c = 0; c < NCORE; c++) cst_d[c][i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q <= '0;  pend_q <= '0;
      for (int c = 0; c < NCORE; c++) cst_q[c] <= '0;
      for (int i = 0; i < NSRC; i++) begin
        cmap_q[i] <= '0;
        eff_q[i]  <= '0;
      end
      for (int i = 0; i < IPB; i++) ipm_q[i] <= '0;
      for (int i = 0; i < NTB; i++) begin
        nt_q[i] <= '0;
        bo_q[i] <= '0;
      end
      wa_q <= '0;  wd_q <= '0;  wm_q <= '0;  wb_q <= '0;
      rsp_o <= 1'b0;  err_o <= 1'b0;  rdata_o <= '0;
    end else begin
      en_q <= en_d;  pend_q <= pend_d;  cst_q <= cst_d;
      cmap_q <= cmap_d;  eff_q <= eff_d;  ipm_q <= ipm_d;
      nt_q <= nt_d;  bo_q <= bo_d;
      wa_q <= wa_d;  wd_q <= wd_d;  wm_q <= wm_d;  wb_q <= wb_d;
      rsp_o <= rsp_d;  err_o <= err_d;  rdata_o <= rdata_d;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NSRC  = 256,
  parameter int NCORE = 4
) (
  input logic                 clk_i,
  input logic                 rst_i,
  input logic [NSRC-1:0]      src_i,
  input logic                 req_i,
  input logic                 busy_o,
  input logic                 rsp_o,
  input logic                 err_o,
  input logic [63:0]          rdata_o,
  input logic [NCORE*4-1:0]   irq_o
);
  // R1: the first cycle out of reset is idle
  a_r1_reset_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (irq_o == '0 && !busy_o && !rsp_o));

  // R13: accepted request answered next cycle
  a_r13_rsp_after_req: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && !busy_o) |=> rsp_o);

  // R12: nothing answered unless accepted
  a_r12_no_rsp_when_held: assert property (@(posedge clk_i) disable iff (rst_i)
    !(req_i && !busy_o) |=> !rsp_o);

  // R2: errors carry zero data
  a_r2_err_reads_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    (rsp_o && err_o) |-> (rdata_o == '0));

  // R5: with every source low, all parent lines are low next cycle
  a_r5_idle_sources_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (src_i == '0) |=> (irq_o == '0));
endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC), .NCORE(NCORE)) u_chk (.*);

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
  localparam int NS = 64;
  logic clk = 1'b0, rst = 1'b1;
  logic [NS-1:0] src = '0;
  logic req = 1'b0, we = 1'b0;
  logic [1:0] size = '0, core = '0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic rsp, err, busy;
  logic [15:0] irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_router #(.NSRC(NS), .NCORE(4)) u0 (
    .clk_i(clk), .rst_i(rst), .src_i(src), .req_i(req), .we_i(we), .size_i(size),
    .core_i(core), .addr_i(addr), .wdata_i(wdata), .rsp_o(rsp), .rdata_o(rdata),
    .err_o(err), .busy_o(busy), .irq_o(irq));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] sz, input logic [11:0] ad,
                     input logic [63:0] wd, input logic [1:0] cr,
                     output logic [63:0] rd, output logic er);
    while (busy) @(negedge clk);
    req = 1'b1; we = w; size = sz; addr = ad; wdata = wd; core = cr;
    @(negedge clk);
    req = 1'b0;
    rd = rdata; er = err;
    if (rsp !== 1'b1) chk("R13 response", {63'd0, rsp}, 64'd1);
  endtask

  task automatic wr(input logic [1:0] sz, input logic [11:0] ad, input logic [63:0] wd,
                    input logic [1:0] cr);
    logic [63:0] d; logic e;
    acc(1'b1, sz, ad, wd, cr, d, e);
  endtask

  task automatic rdchk(input string tag, input logic [1:0] sz, input logic [11:0] ad,
                       input logic [1:0] cr, input logic [63:0] exp);
    logic [63:0] d; logic e;
    acc(1'b0, sz, ad, 64'd0, cr, d, e);
    chk(tag, d, exp);
  endtask

  task automatic idle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [7:0] cmb(input int s);
    case (s % 6)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h02;
      3: return 8'h0C;  4: return 8'h08;  default: return 8'h30;
    endcase
  endfunction

  function automatic int ecore(input int s);
    case (s % 6)
      2: return 1;  3: return 2;  4: return 3;  default: return 0;
    endcase
  endfunction

  function automatic int eline(input int s);
    return (s < 32) ? 2 : 3;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, exp; logic e; int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 irq", {48'd0, irq}, 64'd0);
    chk("R1 busy", {63'd0, busy}, 64'd0);
    rdchk("R1 enable", 2'd2, 12'h200, 2'd0, 64'd0);
    rdchk("R1 coremap", 2'd2, 12'h800, 2'd0, 64'd0);
    rdchk("R1 linemap", 2'd0, 12'h0C0, 2'd0, 64'd0);

    // configuration
    wr(2'd0, 12'h0C0, 64'h04, 2'd0);
    wr(2'd0, 12'h0C1, 64'h18, 2'd0);
    for (int s = 0; s < NS; s++) wr(2'd0, 12'(12'h800 + s), {56'd0, cmb(s)}, 2'd0);
    wr(2'd2, 12'h200, '1, 2'd0);
    exp = '0;
    for (int s = 0; s < 8; s++) exp[s*8 +: 8] = cmb(s);
    rdchk("R11 coremap 8B readback", 2'd2, 12'h800, 2'd0, exp);

    // R3/R4/R5 sweep over every source
    for (int s = 0; s < NS; s++) begin
      src = '0; src[s] = 1'b1;
      @(negedge clk);
      chk($sformatf("R3 R4 irq src %0d", s), {48'd0, irq}, 64'd1 << (ecore(s)*4 + eline(s)));
      rdchk($sformatf("R6 global src %0d", s), 2'd2, 12'h300, 2'd0, 64'd1 << s);
      rdchk($sformatf("R3 own core src %0d", s), 2'd2, 12'h400, 2'(ecore(s)), 64'd1 << s);
      rdchk($sformatf("R4 other core src %0d", s), 2'd2, 12'h400, 2'((ecore(s)+1) % 4), 64'd0);
      src = '0;
      @(negedge clk);
      chk($sformatf("R5 drop src %0d", s), {48'd0, irq}, 64'd0);
    end

    // R5 shared line
    src = '0; src[0] = 1'b1; src[6] = 1'b1;
    @(negedge clk);
    chk("R5 two on line", {48'd0, irq}, 64'h4);
    src[0] = 1'b0;
    @(negedge clk);
    chk("R5 one left holds line", {48'd0, irq}, 64'h4);
    src[6] = 1'b0;
    @(negedge clk);
    chk("R5 none left", {48'd0, irq}, 64'h0);

    // R6 disabled source, R12 busy length
    wr(2'd0, 12'h200, 64'h00, 2'd0);
    chk("R12 no work no busy", {63'd0, busy}, 64'd0);
    src[3:0] = 4'hF;
    @(negedge clk);
    chk("R6 disabled not routed", {48'd0, irq}, 64'd0);
    rdchk("R6 pending latched", 2'd0, 12'h300, 2'd0, 64'h0F);
    wr(2'd0, 12'h200, 64'hFF, 2'd0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R12 busy cycles", 64'(n), 64'd4);
    chk("R8 enable rise routes", {48'd0, irq}, 64'h0444);

    wr(2'd0, 12'h200, 64'h00, 2'd0);
    req = 1'b1; we = 1'b0; size = 2'd0; addr = 12'h300;
    @(negedge clk);
    req = 1'b0;
    chk("R12 held request dropped", {63'd0, rsp}, 64'd0);
    idle();
    chk("R8 enable fall deroutes", {48'd0, irq}, 64'd0);
    rdchk("R8 enable byte", 2'd0, 12'h200, 2'd0, 64'h00);
    wr(2'd0, 12'h200, 64'hFF, 2'd0);
    idle();
    chk("R8 re-enable", {48'd0, irq}, 64'h0444);

    // R7 write-one-to-clear
    wr(2'd0, 12'h400, 64'h03, 2'd0);
    idle();
    chk("R7 cleared line drops", {48'd0, irq}, 64'h0440);
    rdchk("R7 core0 copy", 2'd0, 12'h400, 2'd0, 64'h00);
    rdchk("R7 core1 copy", 2'd0, 12'h400, 2'd1, 64'h04);
    wr(2'd0, 12'h400, 64'h01, 2'd1);
    chk("R7 nothing cleared no busy", {63'd0, busy}, 64'd0);
    rdchk("R7 core1 untouched", 2'd0, 12'h400, 2'd1, 64'h04);
    rdchk("R7 address core field ignored", 2'd0, 12'h500, 2'd2, 64'h08);
    rdchk("R7 global kept", 2'd0, 12'h300, 2'd0, 64'h0F);

    // R9 move
    wr(2'd0, 12'h803, 64'h08, 2'd0);
    idle();
    chk("R9 moved", {48'd0, irq}, 64'h4040);
    rdchk("R9 new core copy", 2'd0, 12'h400, 2'd3, 64'h08);
    rdchk("R9 old core copy", 2'd0, 12'h400, 2'd2, 64'h00);
    wr(2'd0, 12'h803, 64'h08, 2'd0);
    chk("R9 unchanged no busy", {63'd0, busy}, 64'd0);
    chk("R9 unchanged irq", {48'd0, irq}, 64'h4040);

    // R3 line map recomputed
    wr(2'd0, 12'h0C0, 64'h00, 2'd0);
    @(negedge clk);
    chk("R3 empty line map", {48'd0, irq}, 64'h1010);
    wr(2'd0, 12'h0C0, 64'h20, 2'd0);
    @(negedge clk);
    chk("R3 high bit line map", {48'd0, irq}, 64'h1010);
    wr(2'd0, 12'h0C0, 64'h04, 2'd0);
    @(negedge clk);
    chk("R3 restored", {48'd0, irq}, 64'h4040);

    // R10 / R11
    wr(2'd1, 12'h0A4, 64'hDEADBEEF, 2'd0);
    rdchk("R11 aligned down 4B", 2'd1, 12'h0A5, 2'd0, 64'hDEADBEEF);
    rdchk("R11 little endian", 2'd0, 12'h0A6, 2'd0, 64'hAD);
    wr(2'd2, 12'h280, 64'h0123456789ABCDEF, 2'd0);
    rdchk("R10 bounce readback", 2'd2, 12'h280, 2'd0, 64'h0123456789ABCDEF);
    chk("R10 no routing effect", {48'd0, irq}, 64'h4040);

    // R2 errors, R6 global write ignored
    acc(1'b0, 2'd0, 12'h100, 64'd0, 2'd0, d, e);
    chk("R2 unmapped err", {63'd0, e}, 64'd1);
    chk("R2 unmapped data", d, 64'd0);
    acc(1'b0, 2'd3, 12'h200, 64'd0, 2'd0, d, e);
    chk("R2 bad size err", {63'd0, e}, 64'd1);
    acc(1'b0, 2'd2, 12'h208, 64'd0, 2'd0, d, e);
    chk("R2 past enable err", {63'd0, e}, 64'd1);
    acc(1'b1, 2'd0, 12'h120, 64'hFF, 2'd0, d, e);
    chk("R2 unmapped write err", {63'd0, e}, 64'd1);
    acc(1'b1, 2'd0, 12'h300, 64'h00, 2'd0, d, e);
    chk("R6 global write no err", {63'd0, e}, 64'd0);
    rdchk("R6 global write ignored", 2'd0, 12'h300, 2'd0, 64'h0F);
    chk("R2 no state change", {48'd0, irq}, 64'h4040);

    src = '0;
    @(negedge clk);
    chk("R5 all low", {48'd0, irq}, 64'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule